// File: doc/BRIEF.md
# Three-Level Strided Copy Address Sequencer

This block turns one programmed copy into an ordered stream of row descriptors. A copy is described by a source base and a destination base, the trip counts of two hardware loops (outer and inner), one stride per loop on each side, a row count, a start-to-start row stride on each side, and a burst length in bytes. On a start pulse the block takes a copy of the whole configuration. It then walks the nested loops with the outer loop slowest, the inner loop next and the row index fastest. For every row it offers one descriptor on a valid/ready stream. Each descriptor holds a source address, a destination address and the byte count. The block moves no data itself.

One side of every copy is the wide global-memory space. The other side is a narrow local buffer whose addresses must sit on 32-byte boundaries. A direction input selects which side is the source: in a load the source is global memory, and in a store the source is the local buffer. The wide side and the narrow side keep their own address widths, so the stride widths swap with the direction. Address arithmetic uses running adders that reload the saved loop base at each loop boundary. A configuration that cannot be walked is rejected at start: an error pulse is raised and no descriptor is emitted.

Top module: `dma_stride_seq`

## Requirements
- R1: After reset the block is idle: `busy_o`, `desc_valid_o`, `done_o` and `err_o` are all 0.
- R2: Descriptors appear in the order outer index j (slowest), inner index k, then row index r (fastest). Source and destination each equal base + j*outer_stride + k*inner_stride + r*row_stride for their own side, taken modulo that side's address width.
- R3: Every descriptor carries the programmed burst length in `desc_len_o`. Exactly outer_count*inner_count*rows descriptors are emitted per copy.
- R4: With `cfg_dir_i`=0 (load) the source is the wide side (WIDE_W bits) and the destination is the narrow side. With `cfg_dir_i`=1 (store) the roles swap. Narrow-side base and strides use only their low NARROW_W bits, narrow addresses wrap modulo 2^NARROW_W, and the upper bits of the narrow address on the output port are 0.
- R5: `done_o` is high for exactly one cycle, in the cycle after the handshake of the last descriptor. `busy_o` is 0 in the cycle after that.
- R6: A start with a zero outer count, a zero inner count or a zero row count is rejected. `err_o` is high for one cycle, in the cycle after start, and no descriptor is offered.
- R7: A start is rejected in the same way if either side's row stride (the narrow one after truncation) is smaller than the burst length.
- R8: A start is rejected in the same way if the narrow-side base or any narrow-side stride has a nonzero value in its low 5 bits. Every narrow-side address that is emitted is a multiple of 32.
- R9: While busy, a start pulse is ignored and changes on the configuration inputs have no effect on the copy in progress.
- R10: While `desc_valid_o` is high and `desc_ready_i` is low, the descriptor stays valid and unchanged.
- R11: A load with inner count 4, inner strides 2048/2048, 8 rows of 256 bytes and row strides 256 emits four groups of 8 rows. The groups start at offsets 0, 2048, 4096 and 6144 on both sides.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse; captures the configuration when idle |
| cfg_dir_i | input | 1 | 0 = load (source wide side), 1 = store (source narrow side) |
| cfg_src_base_i | input | WIDE_W | Source base address |
| cfg_dst_base_i | input | WIDE_W | Destination base address |
| cfg_outer_cnt_i | input | CNT_W | Outer loop trip count |
| cfg_inner_cnt_i | input | CNT_W | Inner loop trip count |
| cfg_rows_i | input | ROW_W | Rows per inner iteration |
| cfg_len_i | input | LEN_W | Burst length in bytes |
| cfg_src_outer_stride_i | input | WIDE_W | Source advance per outer iteration |
| cfg_dst_outer_stride_i | input | WIDE_W | Destination advance per outer iteration |
| cfg_src_inner_stride_i | input | WIDE_W | Source advance per inner iteration |
| cfg_dst_inner_stride_i | input | WIDE_W | Destination advance per inner iteration |
| cfg_src_row_stride_i | input | WIDE_W | Source start-to-start row distance |
| cfg_dst_row_stride_i | input | WIDE_W | Destination start-to-start row distance |
| busy_o | output | 1 | A copy is running or finishing |
| desc_valid_o | output | 1 | Descriptor offered |
| desc_ready_i | input | 1 | Descriptor accepted |
| desc_src_o | output | WIDE_W | Row source address |
| desc_dst_o | output | WIDE_W | Row destination address |
| desc_len_o | output | LEN_W | Row byte count |
| done_o | output | 1 | One-cycle pulse after the last descriptor |
| err_o | output | 1 | One-cycle pulse when a start is rejected |

## Verification
The bench sweeps every combination of outer count 1..2, inner count 1..3 and row count 1..3 in both directions. This separates a wrong loop nesting order from a wrong stride, and a swapped wide/narrow side from a correct one. Part of the sweep runs with back-pressure, which shows whether stalls repeat or skip rows. Bases near the top of each address space show whether the wrap differs between the 40-bit and the 21-bit side, and a narrow stride with junk upper bits shows that those bits are dropped. A start pulse with changed configuration in the middle of a copy, together with one rejected start per error condition, separates the rules for ignoring a start from the rules for rejecting one.

// File: rtl/dma_seq_pkg.sv
`timescale 1ns/1ps
package dma_seq_pkg;

    localparam int WIDE_AW   = 40;
    localparam int NARROW_AW = 21;
    localparam int LOOP_CW   = 21;
    localparam int ROW_CW    = 12;
    localparam int ALIGN_LG  = 5;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_DONE  = 2'd2,
        ST_ABORT = 2'd3
    } seq_state_t;

    typedef enum logic {
        DIR_LOAD  = 1'b0,
        DIR_STORE = 1'b1
    } xfer_dir_t;

    // true when the low lg bits of v are all zero
    function automatic logic is_aligned(input logic [63:0] v, input int unsigned lg);
        logic [63:0] m;
        m = (64'd1 << lg) - 64'd1;
        return (v & m) == 64'd0;
    endfunction

    // true when a start-to-start distance leaves room for one burst
    function automatic logic stride_covers(input logic [63:0] stride, input logic [63:0] len);
        return stride >= len;
    endfunction

endpackage

// File: rtl/dma_seq_cfg_check.sv
`timescale 1ns/1ps
module dma_seq_cfg_check
    import dma_seq_pkg::*;
#(
    parameter int WIDE_W   = WIDE_AW,
    parameter int NARROW_W = NARROW_AW,
    parameter int CNT_W    = LOOP_CW,
    parameter int ROW_W    = ROW_CW,
    parameter int LEN_W    = NARROW_AW,
    parameter int ALIGN_W  = ALIGN_LG
) (
    input  logic [CNT_W-1:0]    outer_cnt,
    input  logic [CNT_W-1:0]    inner_cnt,
    input  logic [ROW_W-1:0]    rows,
    input  logic [LEN_W-1:0]    len,
    input  logic [WIDE_W-1:0]   gm_row_stride,
    input  logic [NARROW_W-1:0] lb_base,
    input  logic [NARROW_W-1:0] lb_outer_stride,
    input  logic [NARROW_W-1:0] lb_inner_stride,
    input  logic [NARROW_W-1:0] lb_row_stride,
    output logic                bad
);

    logic zero_trip;
    logic short_row;
    logic misaligned;

    always_comb begin
        zero_trip  = (outer_cnt == '0) || (inner_cnt == '0) || (rows == '0);
        short_row  = !stride_covers(64'(gm_row_stride), 64'(len)) ||
                     !stride_covers(64'(lb_row_stride), 64'(len));
        misaligned = !is_aligned(64'(lb_base), ALIGN_W) ||
                     !is_aligned(64'(lb_outer_stride), ALIGN_W) ||
                     !is_aligned(64'(lb_inner_stride), ALIGN_W) ||
                     !is_aligned(64'(lb_row_stride), ALIGN_W);
        bad        = zero_trip || short_row || misaligned;
    end

endmodule

// File: rtl/dma_seq_loops.sv
`timescale 1ns/1ps
module dma_seq_loops
    import dma_seq_pkg::*;
#(
    parameter int CNT_W = LOOP_CW,
    parameter int ROW_W = ROW_CW
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             step,
    input  logic             active,
    input  logic [CNT_W-1:0] lim_outer,
    input  logic [CNT_W-1:0] lim_inner,
    input  logic [ROW_W-1:0] lim_rows,
    output logic             row_last,
    output logic             inner_last,
    output logic             outer_last
);

    logic [CNT_W-1:0] outer_idx;
    logic [CNT_W-1:0] inner_idx;
    logic [ROW_W-1:0] row_idx;

    assign row_last   = (row_idx   == lim_rows  - ROW_W'(1));
    assign inner_last = (inner_idx == lim_inner - CNT_W'(1));
    assign outer_last = (outer_idx == lim_outer - CNT_W'(1));

    always_ff @(posedge clk) begin
        if (rst || load) begin
            outer_idx <= '0;
            inner_idx <= '0;
            row_idx   <= '0;
        end else if (step) begin
            if (!row_last) begin
                row_idx <= row_idx + ROW_W'(1);
            end else begin
                row_idx <= '0;
                if (!inner_last) begin
                    inner_idx <= inner_idx + CNT_W'(1);
                end else begin
                    inner_idx <= '0;
                    outer_idx <= outer_idx + CNT_W'(1);
                end
            end
        end
    end

    // R2
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        active |-> (row_idx < lim_rows) && (inner_idx < lim_inner) && (outer_idx < lim_outer));

endmodule

// File: rtl/dma_seq_walk.sv
`timescale 1ns/1ps
module dma_seq_walk #(
    parameter int AW = 40
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic          step,
    input  logic          row_last,
    input  logic          inner_last,
    input  logic [AW-1:0] base,
    input  logic [AW-1:0] outer_stride,
    input  logic [AW-1:0] inner_stride,
    input  logic [AW-1:0] row_stride,
    output logic [AW-1:0] addr
);

    logic [AW-1:0] outer_base;
    logic [AW-1:0] inner_base;
    logic [AW-1:0] row_addr;
    logic [AW-1:0] next_inner;
    logic [AW-1:0] next_outer;

    assign next_inner = inner_base + inner_stride;
    assign next_outer = outer_base + outer_stride;
    assign addr       = row_addr;

    always_ff @(posedge clk) begin
        if (rst) begin
            outer_base <= '0;
            inner_base <= '0;
            row_addr   <= '0;
        end else if (load) begin
            outer_base <= base;
            inner_base <= base;
            row_addr   <= base;
        end else if (step) begin
            if (!row_last) begin
                row_addr <= row_addr + row_stride;
            end else if (!inner_last) begin
                inner_base <= next_inner;
                row_addr   <= next_inner;
            end else begin
                outer_base <= next_outer;
                inner_base <= next_outer;
                row_addr   <= next_outer;
            end
        end
    end

endmodule

// File: rtl/dma_stride_seq.sv
`timescale 1ns/1ps
module dma_stride_seq
    import dma_seq_pkg::*;
#(
    parameter int WIDE_W   = WIDE_AW,
    parameter int NARROW_W = NARROW_AW,
    parameter int CNT_W    = LOOP_CW,
    parameter int ROW_W    = ROW_CW,
    parameter int LEN_W    = NARROW_AW,
    parameter int ALIGN_W  = ALIGN_LG
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              cfg_dir_i,
    input  logic [WIDE_W-1:0] cfg_src_base_i,
    input  logic [WIDE_W-1:0] cfg_dst_base_i,
    input  logic [CNT_W-1:0]  cfg_outer_cnt_i,
    input  logic [CNT_W-1:0]  cfg_inner_cnt_i,
    input  logic [ROW_W-1:0]  cfg_rows_i,
    input  logic [LEN_W-1:0]  cfg_len_i,
    input  logic [WIDE_W-1:0] cfg_src_outer_stride_i,
    input  logic [WIDE_W-1:0] cfg_dst_outer_stride_i,
    input  logic [WIDE_W-1:0] cfg_src_inner_stride_i,
    input  logic [WIDE_W-1:0] cfg_dst_inner_stride_i,
    input  logic [WIDE_W-1:0] cfg_src_row_stride_i,
    input  logic [WIDE_W-1:0] cfg_dst_row_stride_i,
    output logic              busy_o,
    output logic              desc_valid_o,
    input  logic              desc_ready_i,
    output logic [WIDE_W-1:0] desc_src_o,
    output logic [WIDE_W-1:0] desc_dst_o,
    output logic [LEN_W-1:0]  desc_len_o,
    output logic              done_o,
    output logic              err_o
);

    localparam int PAD_W = WIDE_W - NARROW_W;

    typedef struct packed {
        logic [WIDE_W-1:0] outer;
        logic [WIDE_W-1:0] inner;
        logic [WIDE_W-1:0] row;
    } wide_strides_t;

    typedef struct packed {
        logic [NARROW_W-1:0] outer;
        logic [NARROW_W-1:0] inner;
        logic [NARROW_W-1:0] row;
    } narrow_strides_t;

    // side selection from the live inputs
    logic [WIDE_W-1:0]   gm_base_in;
    logic [NARROW_W-1:0] lb_base_in;
    wide_strides_t       gm_str_in;
    narrow_strides_t     lb_str_in;

    always_comb begin
        if (xfer_dir_t'(cfg_dir_i) == DIR_STORE) begin
            gm_base_in      = cfg_dst_base_i;
            gm_str_in.outer = cfg_dst_outer_stride_i;
            gm_str_in.inner = cfg_dst_inner_stride_i;
            gm_str_in.row   = cfg_dst_row_stride_i;
            lb_base_in      = cfg_src_base_i[NARROW_W-1:0];
            lb_str_in.outer = cfg_src_outer_stride_i[NARROW_W-1:0];
            lb_str_in.inner = cfg_src_inner_stride_i[NARROW_W-1:0];
            lb_str_in.row   = cfg_src_row_stride_i[NARROW_W-1:0];
        end else begin
            gm_base_in      = cfg_src_base_i;
            gm_str_in.outer = cfg_src_outer_stride_i;
            gm_str_in.inner = cfg_src_inner_stride_i;
            gm_str_in.row   = cfg_src_row_stride_i;
            lb_base_in      = cfg_dst_base_i[NARROW_W-1:0];
            lb_str_in.outer = cfg_dst_outer_stride_i[NARROW_W-1:0];
            lb_str_in.inner = cfg_dst_inner_stride_i[NARROW_W-1:0];
            lb_str_in.row   = cfg_dst_row_stride_i[NARROW_W-1:0];
        end
    end

    logic cfg_bad;

    dma_seq_cfg_check #(
        .WIDE_W   (WIDE_W),
        .NARROW_W (NARROW_W),
        .CNT_W    (CNT_W),
        .ROW_W    (ROW_W),
        .LEN_W    (LEN_W),
        .ALIGN_W  (ALIGN_W)
    ) u_check (
        .outer_cnt       (cfg_outer_cnt_i),
        .inner_cnt       (cfg_inner_cnt_i),
        .rows            (cfg_rows_i),
        .len             (cfg_len_i),
        .gm_row_stride   (gm_str_in.row),
        .lb_base         (lb_base_in),
        .lb_outer_stride (lb_str_in.outer),
        .lb_inner_stride (lb_str_in.inner),
        .lb_row_stride   (lb_str_in.row),
        .bad             (cfg_bad)
    );

    // control
    seq_state_t      state;
    logic            launch;
    logic            reject;
    logic            fire;
    logic            row_last;
    logic            inner_last;
    logic            outer_last;
    logic            final_row;

    xfer_dir_t       dir_q;
    logic [LEN_W-1:0] len_q;
    logic [CNT_W-1:0] outer_cnt_q;
    logic [CNT_W-1:0] inner_cnt_q;
    logic [ROW_W-1:0] rows_q;
    wide_strides_t   gm_str_q;
    narrow_strides_t lb_str_q;

    assign launch    = (state == ST_IDLE) && start_i && !cfg_bad;
    assign reject    = (state == ST_IDLE) && start_i && cfg_bad;
    assign fire      = desc_valid_o && desc_ready_i;
    assign final_row = row_last && inner_last && outer_last;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (launch)      state <= ST_RUN;
                    else if (reject) state <= ST_ABORT;
                end
                ST_RUN:   if (fire && final_row) state <= ST_DONE;
                ST_DONE:  state <= ST_IDLE;
                ST_ABORT: state <= ST_IDLE;
                default:  state <= ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dir_q       <= DIR_LOAD;
            len_q       <= '0;
            outer_cnt_q <= '0;
            inner_cnt_q <= '0;
            rows_q      <= '0;
            gm_str_q    <= '0;
            lb_str_q    <= '0;
        end else if (launch) begin
            dir_q       <= xfer_dir_t'(cfg_dir_i);
            len_q       <= cfg_len_i;
            outer_cnt_q <= cfg_outer_cnt_i;
            inner_cnt_q <= cfg_inner_cnt_i;
            rows_q      <= cfg_rows_i;
            gm_str_q    <= gm_str_in;
            lb_str_q    <= lb_str_in;
        end
    end

    dma_seq_loops #(
        .CNT_W (CNT_W),
        .ROW_W (ROW_W)
    ) u_loops (
        .clk        (clk),
        .rst        (rst),
        .load       (launch),
        .step       (fire),
        .active     (state == ST_RUN),
        .lim_outer  (outer_cnt_q),
        .lim_inner  (inner_cnt_q),
        .lim_rows   (rows_q),
        .row_last   (row_last),
        .inner_last (inner_last),
        .outer_last (outer_last)
    );

    logic [WIDE_W-1:0]   gm_addr;
    logic [NARROW_W-1:0] lb_addr;

    dma_seq_walk #(.AW(WIDE_W)) u_gm_walk (
        .clk          (clk),
        .rst          (rst),
        .load         (launch),
        .step         (fire),
        .row_last     (row_last),
        .inner_last   (inner_last),
        .base         (gm_base_in),
        .outer_stride (gm_str_q.outer),
        .inner_stride (gm_str_q.inner),
        .row_stride   (gm_str_q.row),
        .addr         (gm_addr)
    );

    dma_seq_walk #(.AW(NARROW_W)) u_lb_walk (
        .clk          (clk),
        .rst          (rst),
        .load         (launch),
        .step         (fire),
        .row_last     (row_last),
        .inner_last   (inner_last),
        .base         (lb_base_in),
        .outer_stride (lb_str_q.outer),
        .inner_stride (lb_str_q.inner),
        .row_stride   (lb_str_q.row),
        .addr         (lb_addr)
    );

    logic [WIDE_W-1:0] lb_addr_wide;
    assign lb_addr_wide = {{PAD_W{1'b0}}, lb_addr};

    assign desc_src_o   = (dir_q == DIR_STORE) ? lb_addr_wide : gm_addr;
    assign desc_dst_o   = (dir_q == DIR_STORE) ? gm_addr : lb_addr_wide;
    assign desc_len_o   = len_q;
    assign desc_valid_o = (state == ST_RUN);
    assign busy_o       = (state != ST_IDLE);
    assign done_o       = (state == ST_DONE);
    assign err_o        = (state == ST_ABORT);

    // R10
    desc_hold_chk: assert property (@(posedge clk) disable iff (rst)
        desc_valid_o && !desc_ready_i |=> desc_valid_o && $stable(desc_src_o)
                                          && $stable(desc_dst_o) && $stable(desc_len_o));

    // R8
    lb_align_chk: assert property (@(posedge clk) disable iff (rst)
        desc_valid_o |-> lb_addr[ALIGN_W-1:0] == '0);

    // R5
    done_after_last_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |-> $past(desc_valid_o && desc_ready_i));

    // R9
    cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (state != ST_IDLE) && ($past(state) != ST_IDLE)
            |-> $stable(len_q) && $stable(dir_q) && $stable(gm_str_q) && $stable(lb_str_q));

    // R6
    abort_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        err_o |=> !desc_valid_o && !done_o);

endmodule

// File: tb/dma_stride_seq_tb_top.sv
`timescale 1ns/1ps
module dma_stride_seq_tb_top;

    localparam int WW = 40;
    localparam int NW = 21;
    localparam int CW = 21;
    localparam int RW = 12;
    localparam int LW = 21;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic          cfg_dir = 1'b0;
    logic [WW-1:0] cfg_sb = '0, cfg_db = '0;
    logic [CW-1:0] cfg_n2 = '0, cfg_n1 = '0;
    logic [RW-1:0] cfg_nr = '0;
    logic [LW-1:0] cfg_len = '0;
    logic [WW-1:0] cfg_s2s = '0, cfg_s2d = '0, cfg_s1s = '0, cfg_s1d = '0;
    logic [WW-1:0] cfg_rss = '0, cfg_rsd = '0;
    logic          busy, dvalid, done, err;
    logic          dready = 1'b0;
    logic [WW-1:0] dsrc, ddst;
    logic [LW-1:0] dlen;

    always #2.5 clk = ~clk;

    dma_stride_seq dut_i (
        .clk                    (clk),
        .rst                    (rst),
        .start_i                (start),
        .cfg_dir_i              (cfg_dir),
        .cfg_src_base_i         (cfg_sb),
        .cfg_dst_base_i         (cfg_db),
        .cfg_outer_cnt_i        (cfg_n2),
        .cfg_inner_cnt_i        (cfg_n1),
        .cfg_rows_i             (cfg_nr),
        .cfg_len_i              (cfg_len),
        .cfg_src_outer_stride_i (cfg_s2s),
        .cfg_dst_outer_stride_i (cfg_s2d),
        .cfg_src_inner_stride_i (cfg_s1s),
        .cfg_dst_inner_stride_i (cfg_s1d),
        .cfg_src_row_stride_i   (cfg_rss),
        .cfg_dst_row_stride_i   (cfg_rsd),
        .busy_o                 (busy),
        .desc_valid_o           (dvalid),
        .desc_ready_i           (dready),
        .desc_src_o             (dsrc),
        .desc_dst_o             (ddst),
        .desc_len_o             (dlen),
        .done_o                 (done),
        .err_o                  (err)
    );

    int checks = 0;
    int errors = 0;

    bit              t_dir;
    longint unsigned t_sb, t_db, t_s2s, t_s2d, t_s1s, t_s1d, t_rss, t_rsd;
    int              t_n2, t_n1, t_nr, t_len;

    task automatic check(input bit ok, input string tag, input string what,
                         input longint unsigned act, input longint unsigned exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic longint unsigned msk(input longint unsigned v, input int w);
        return v & ((64'd1 << w) - 64'd1);
    endfunction

    task automatic drive_cfg();
        cfg_dir = t_dir;
        cfg_sb  = t_sb[WW-1:0];
        cfg_db  = t_db[WW-1:0];
        cfg_n2  = CW'(t_n2);
        cfg_n1  = CW'(t_n1);
        cfg_nr  = RW'(t_nr);
        cfg_len = LW'(t_len);
        cfg_s2s = t_s2s[WW-1:0];
        cfg_s2d = t_s2d[WW-1:0];
        cfg_s1s = t_s1s[WW-1:0];
        cfg_s1d = t_s1d[WW-1:0];
        cfg_rss = t_rss[WW-1:0];
        cfg_rsd = t_rsd[WW-1:0];
    endtask

    // sweep configuration: wide side and narrow side values, swapped by direction
    task automatic set_sweep(input bit dir, input int n2, input int n1, input int nr);
        longint unsigned gb, g2, g1, gr, lb, l2, l1, lr;
        t_dir = dir; t_n2 = n2; t_n1 = n1; t_nr = nr;
        t_len = 16 * nr + 8;
        gb = 64'h80_0000_1000 + 64'(n1 * 8);
        g2 = 64'h40_0000_0000;
        g1 = 64'h1_0000 + 64'(nr * 256);
        gr = 64'(t_len + 4 * n2);
        lb = 64'h1_0000 + 64'(n1 * 32);
        l2 = 64'h4000;
        l1 = 64'h800;
        lr = 64'(64 * nr);
        if (!dir) begin
            t_sb = gb; t_s2s = g2; t_s1s = g1; t_rss = gr;
            t_db = lb; t_s2d = l2; t_s1d = l1; t_rsd = lr;
        end else begin
            t_sb = lb; t_s2s = l2; t_s1s = l1; t_rss = lr;
            t_db = gb; t_s2d = g2; t_s1d = g1; t_rsd = gr;
        end
    endtask

    task automatic run_copy(input bit stall, input bit disturb, input string tag);
        int sw, dw, st;
        bit dist_done;
        longint unsigned es, ed;
        bit got, rdy;
        sw = t_dir ? NW : WW;
        dw = t_dir ? WW : NW;
        st = 0;
        dist_done = 0;
        @(negedge clk);
        drive_cfg();
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int j = 0; j < t_n2; j++) begin
            for (int k = 0; k < t_n1; k++) begin
                for (int r = 0; r < t_nr; r++) begin
                    es = msk(t_sb + 64'(j) * t_s2s + 64'(k) * t_s1s + 64'(r) * t_rss, sw);
                    ed = msk(t_db + 64'(j) * t_s2d + 64'(k) * t_s1d + 64'(r) * t_rsd, dw);
                    got = 0;
                    while (!got) begin
                        rdy = !stall || (st % 3 != 1);
                        st++;
                        dready = rdy;
                        if (disturb && !dist_done && !rdy) begin
                            // R9: start pulse and changed inputs while busy
                            start   = 1'b1;
                            cfg_len = cfg_len + LW'(8);
                            cfg_sb  = ~cfg_sb;
                            cfg_rsd = cfg_rsd + WW'(32);
                            dist_done = 1;
                        end else begin
                            start = 1'b0;
                        end
                        if (rdy) begin
                            check(dvalid == 1'b1, tag, "valid", 64'(dvalid), 64'd1);
                            check(dsrc == es[WW-1:0], tag, "src", 64'(dsrc), es);
                            check(ddst == ed[WW-1:0], tag, "dst", 64'(ddst), ed);
                            check(dlen == LW'(t_len), "R3", "len", 64'(dlen), 64'(t_len));
                            got = 1;
                        end
                        @(negedge clk);
                    end
                end
            end
        end
        dready = 1'b0;
        start  = 1'b0;
        check(done == 1'b1, "R5", "done after last", 64'(done), 64'd1);
        check(dvalid == 1'b0, "R3", "no extra row", 64'(dvalid), 64'd0);
        @(negedge clk);
        check(done == 1'b0 && busy == 1'b0, "R5", "done one cycle, idle",
              64'({done, busy}), 64'd0);
    endtask

    task automatic err_case(input string tag);
        @(negedge clk);
        drive_cfg();
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(err == 1'b1, tag, "err pulse", 64'(err), 64'd1);
        check(dvalid == 1'b0, tag, "no row", 64'(dvalid), 64'd0);
        @(negedge clk);
        check(err == 1'b0 && busy == 1'b0 && dvalid == 1'b0, tag, "back to idle",
              64'({err, busy, dvalid}), 64'd0);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1
        check({busy, dvalid, done, err} == 4'b0, "R1", "reset state",
              64'({busy, dvalid, done, err}), 64'd0);

        // R2 R3 R4 R5 R10: sweep over loop shapes and both directions
        for (int d = 0; d < 2; d++)
            for (int n2 = 1; n2 <= 2; n2++)
                for (int n1 = 1; n1 <= 3; n1++)
                    for (int nr = 1; nr <= 3; nr++) begin
                        set_sweep(d[0], n2, n1, nr);
                        run_copy(n1 == 2, 1'b0, d[0] ? "R4" : "R2");
                    end

        // R11: four groups of eight 256-byte rows
        t_dir = 1'b0; t_n2 = 1; t_n1 = 4; t_nr = 8; t_len = 256;
        t_sb = 0; t_db = 0; t_s2s = 0; t_s2d = 0;
        t_s1s = 2048; t_s1d = 2048; t_rss = 256; t_rsd = 256;
        run_copy(1'b0, 1'b0, "R11");

        // R4: wrap of each side, junk upper bits on a narrow stride
        t_dir = 1'b0; t_n2 = 1; t_n1 = 1; t_nr = 3; t_len = 32;
        t_sb = 64'hFF_FFFF_FFC0; t_rss = 32; t_s1s = 0; t_s2s = 0;
        t_db = 64'h1F_FFE0; t_rsd = 64'hFF_0000_0020; t_s1d = 0; t_s2d = 0;
        run_copy(1'b0, 1'b0, "R4");
        t_dir = 1'b1; t_nr = 4;
        t_sb = 64'hAB_001F_FFC0; t_rss = 32;
        t_db = 64'hFF_FFFF_FFF0; t_rsd = 40;
        run_copy(1'b1, 1'b0, "R4");

        // R9 and R10: start and config changes while busy, under back-pressure
        set_sweep(1'b0, 2, 2, 3);
        run_copy(1'b1, 1'b1, "R9");

        // R6: zero trip counts
        set_sweep(1'b0, 1, 1, 2); t_n2 = 0; err_case("R6");
        set_sweep(1'b1, 1, 1, 2); t_n1 = 0; err_case("R6");
        set_sweep(1'b0, 1, 1, 2); t_nr = 0; err_case("R6");

        // R7: row stride shorter than burst on wide side, then narrow side
        set_sweep(1'b0, 1, 1, 2); t_rss = 64'(t_len - 1); err_case("R7");
        set_sweep(1'b0, 1, 1, 2); t_rsd = 32; err_case("R7");

        // R8: misaligned narrow base and strides
        set_sweep(1'b1, 1, 1, 2); t_sb = t_sb + 16; err_case("R8");
        set_sweep(1'b0, 1, 1, 2); t_s1d = 64'h810; err_case("R8");
        set_sweep(1'b1, 1, 1, 2); t_s2s = 64'h4008; err_case("R8");

        // a normal copy still works after the rejected starts
        set_sweep(1'b1, 2, 1, 2);
        run_copy(1'b0, 1'b0, "R2");

        finish_run();
    end

endmodule